// File: doc/BRIEF.md
# Dual Wiper Register Bank Controller

This block is the register side of a two-channel digital potentiometer. It holds a live code register for each of the two wipers, a stored start-up code for each wiper, five stored general-purpose bytes and a control register. A serial front end hands it one request at a time: an address, a write byte or a read strobe. It also passes on the level of the chip-select line. The block drives two 7-bit wiper codes and one shutdown flag per wiper toward the analog array.

The stored bytes model nonvolatile cells. A write to one of them is staged while the select line is low. The timed commit starts only when the select line rises. While that commit is running, a busy flag in the control register is set and every write is refused. One control bit chooses whether the two wiper addresses reach the live code registers or the stored start-up codes. A stored-code write also moves the wiper at once. After any reset both wipers sit at mid-scale. Once a start-up delay has elapsed, each wiper is reloaded from its stored code. The stored bytes survive the soft reset and are cleared only by the power-on reset.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: Address map: address 0 is wiper 0, address 1 is wiper 1, addresses 2 to 6 are stored general-purpose bytes, address 7 reads 0x00 and ignores writes, and address 8 is the control register. A read returns its byte on `rd_data` one cycle after `req_rd`.
- R2: Control register bit 7 is the access-select bit. It resets to 0. At 1, addresses 0 and 1 reach only the live code registers, and writes there start no stored commit. A live code reads back as {1'b0, code}.
- R3: With bit 7 at 0, addresses 0 and 1 reach the stored start-up code. A write there also loads bits 6:0 of the byte into that wiper's live code. A read there returns the stored byte and leaves the live code unchanged.
- R4: Control register bit 5 is read-only. It reads 1 while a stored commit is running, and during that time every write to any address is refused.
- R5: A stored-byte write is staged. Its commit starts in the cycle after `cs_n` is seen rising, and the stored byte changes only when the commit ends, NV_WRITE_CYCLES cycles later. Until then a read returns the old stored byte.
- R6: Control register bit 6 resets to 1. `wiper_shut[i]` is 1 when `shdn_n` is low or bit 6 is 0, and 0 otherwise. Both conditions reach the flag one registered stage after they change.
- R7: During shutdown all registers stay readable and writable, and the wiper codes keep their values. When shutdown ends, the codes are those held before it, or as later written.
- R8: After `rst` or `por`, both wiper codes are 0x40. After BOOT_CYCLES cycles each wiper is loaded from its stored start-up code. Writes are refused until that load.
- R9: Control register bits 4:0 always read 0. An idle control register reads 0x40.
- R10: The stored bytes keep their contents through `rst`. `por` clears them to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset; stored bytes are kept |
| por | input | 1 | Synchronous active-high power-on reset; clears stored bytes |
| cs_n | input | 1 | Serial chip-select level, active low; its rise starts a staged commit |
| req_wr | input | 1 | Write request strobe, one cycle |
| req_rd | input | 1 | Read request strobe, one cycle |
| req_addr | input | 4 | Register address of the request |
| req_wdata | input | 8 | Write byte |
| shdn_n | input | 1 | External shutdown input, active low |
| rd_data | output | 8 | Read byte, registered |
| wiper0_code | output | 7 | Wiper 0 tap code, registered |
| wiper1_code | output | 7 | Wiper 1 tap code, registered |
| wiper_shut | output | 2 | Per-wiper shutdown flag, registered |

## Verification
The bench builds the block with NV_WRITE_CYCLES = 40 and BOOT_CYCLES = 16 in place of the millisecond-scale defaults. With these values a whole commit and a whole start-up reload each fit inside a short directed test. That brings within reach the busy window and its write lockout, reads of the old stored byte before the commit ends, and the mid-scale-then-reload sequence after both kinds of reset. The short windows also let the bench check that the stored bytes survive a soft reset but not a power-on reset.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = 7;
  localparam int NUM_WIPERS = 2;
  localparam int NV_ENTRIES = 7;

  localparam logic [ADDR_W-1:0] ADDR_GP_LO = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_GP_HI = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd8;

  localparam logic [CODE_W-1:0] CODE_MID = 7'h40;

  // bit positions inside the control register
  localparam int CTRL_SEL_BIT  = 7;
  localparam int CTRL_RUN_BIT  = 6;
  localparam int CTRL_BUSY_BIT = 5;
endpackage

// File: rtl/wbk_nv_store.sv
module wbk_nv_store #(
  parameter int ENTRIES      = 7,
  parameter int DW           = 8,
  parameter int AW           = 4,
  parameter int NW           = 2,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por,
  input  logic                 cs_n,
  input  logic                 stage_we,
  input  logic [AW-1:0]        stage_addr,
  input  logic [DW-1:0]        stage_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_byte,
  output logic                 busy,
  output logic [NW-1:0][DW-1:0] init_vals
);
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [DW-1:0] cells [ENTRIES];
  logic          cs_q;
  logic          pend_q;
  logic [IW-1:0] pend_idx;
  logic [DW-1:0] pend_data;
  logic [CW-1:0] cnt_q;
  logic          cs_rise;
  logic          commit;

  assign cs_rise = cs_n && !cs_q;
  assign commit  = busy && (cnt_q == CW'(WRITE_CYCLES - 1));

  // cell array: only power-on clears it
  always_ff @(posedge clk) begin
    if (por) begin
      for (int k = 0; k < ENTRIES; k++) cells[k] <= '0;
    end else if (commit) begin
      cells[pend_idx] <= pend_data;
    end
  end

  // staging and self-timed commit
  always_ff @(posedge clk) begin
    if (rst || por) begin
      cs_q      <= 1'b1;
      pend_q    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      busy      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      cs_q <= cs_n;
      if (stage_we && !busy) begin
        pend_q    <= 1'b1;
        pend_idx  <= stage_addr[IW-1:0];
        pend_data <= stage_data;
      end
      if (busy) begin
        if (commit) begin
          busy  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cs_rise && pend_q) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_byte = (rd_addr < AW'(ENTRIES)) ? cells[rd_addr[IW-1:0]] : '0;

  for (genvar g = 0; g < NW; g++) begin : g_init
    assign init_vals[g] = cells[g];
  end

  // R5: a commit only ever starts from a chip-select rise
  assert_start_on_cs_R5: assert property (@(posedge clk) disable iff (rst || por)
    $rose(busy) |-> ($past(cs_n) && !$past(cs_q)));

  for (genvar k = 0; k < ENTRIES; k++) begin : g_hold
    // R5: cells move only at the end of a running commit
    assert_cell_hold_R5: assert property (@(posedge clk) disable iff (por)
      !busy |=> $stable(cells[k]));
  end
endmodule

// File: rtl/wbk_boot_seq.sv
module wbk_boot_seq #(
  parameter int BOOT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_any,
  output logic booting,
  output logic fire
);
  localparam int BW = $clog2(BOOT_CYCLES + 1);
  logic [BW-1:0] cnt_q;

  assign fire = booting && (cnt_q == BW'(BOOT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst_any) begin
      booting <= 1'b1;
      cnt_q   <= '0;
    end else if (booting) begin
      if (fire) booting <= 1'b0;
      else      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R8: the reload fires exactly once per reset
  assert_boot_once_R8: assert property (@(posedge clk) disable iff (rst_any)
    fire |=> (!booting && !fire));
endmodule

// File: rtl/wbk_wiper_out.sv
module wbk_wiper_out #(
  parameter int NW = 2,
  parameter int CW = 7
) (
  input  logic                 clk,
  input  logic                 rst_any,
  input  logic                 shdn_n,
  input  logic                 run_bit,
  input  logic [NW-1:0][CW-1:0] codes_in,
  output logic [NW-1:0][CW-1:0] codes_out,
  output logic [NW-1:0]        shut_out
);
  for (genvar g = 0; g < NW; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst_any) begin
        codes_out[g] <= wbk_pkg::CODE_MID;
        shut_out[g]  <= 1'b0;
      end else begin
        codes_out[g] <= codes_in[g];
        shut_out[g]  <= !(shdn_n && run_bit);
      end
    end

    // R6: external pin low forces the flag
    assert_shut_pin_R6: assert property (@(posedge clk) disable iff (rst_any)
      !shdn_n |=> shut_out[g]);
    // R6: control bit low forces the flag
    assert_shut_bit_R6: assert property (@(posedge clk) disable iff (rst_any)
      !run_bit |=> shut_out[g]);
  end
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl #(
  parameter int NV_WRITE_CYCLES = 1_000_000,
  parameter int BOOT_CYCLES     = 150_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por,
  input  logic       cs_n,
  input  logic       req_wr,
  input  logic       req_rd,
  input  logic [3:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       shdn_n,
  output logic [7:0] rd_data,
  output logic [6:0] wiper0_code,
  output logic [6:0] wiper1_code,
  output logic [1:0] wiper_shut
);
  import wbk_pkg::*;

  localparam int NW = NUM_WIPERS;

  logic                          rst_any;
  logic                          busy;
  logic                          booting;
  logic                          boot_fire;
  logic                          sel_vol;
  logic                          run_bit;
  logic [NW-1:0][CODE_W-1:0]     live_q;
  logic [NW-1:0][CODE_W-1:0]     codes_out;
  logic [NW-1:0][DATA_W-1:0]     init_vals;
  logic [DATA_W-1:0]             nv_byte;
  logic                          wr_ok;
  logic                          is_wiper;
  logic                          is_gp;
  logic                          is_ctrl;
  logic                          stage_we;

  assign rst_any  = rst || por;
  assign is_wiper = req_addr < ADDR_W'(NW);
  assign is_gp    = (req_addr >= ADDR_GP_LO) && (req_addr <= ADDR_GP_HI);
  assign is_ctrl  = req_addr == ADDR_CTRL;
  assign wr_ok    = req_wr && !busy && !booting;
  assign stage_we = wr_ok && ((is_wiper && !sel_vol) || is_gp);

  wbk_nv_store #(
    .ENTRIES(NV_ENTRIES), .DW(DATA_W), .AW(ADDR_W), .NW(NW),
    .WRITE_CYCLES(NV_WRITE_CYCLES)
  ) u_store (
    .clk(clk), .rst(rst), .por(por), .cs_n(cs_n),
    .stage_we(stage_we), .stage_addr(req_addr), .stage_data(req_wdata),
    .rd_addr(req_addr), .rd_byte(nv_byte), .busy(busy), .init_vals(init_vals)
  );

  wbk_boot_seq #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst_any(rst_any), .booting(booting), .fire(boot_fire)
  );

  // live codes and control bits
  always_ff @(posedge clk) begin
    if (rst_any) begin
      for (int g = 0; g < NW; g++) live_q[g] <= CODE_MID;
      sel_vol <= 1'b0;
      run_bit <= 1'b1;
    end else if (boot_fire) begin
      for (int g = 0; g < NW; g++) live_q[g] <= init_vals[g][CODE_W-1:0];
    end else if (wr_ok) begin
      if (is_ctrl) begin
        sel_vol <= req_wdata[CTRL_SEL_BIT];
        run_bit <= req_wdata[CTRL_RUN_BIT];
      end
      for (int g = 0; g < NW; g++) begin
        if (req_addr == ADDR_W'(g)) live_q[g] <= req_wdata[CODE_W-1:0];
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst_any) begin
      rd_data <= '0;
    end else if (req_rd) begin
      if (is_ctrl) begin
        rd_data <= '0;
        rd_data[CTRL_SEL_BIT]  <= sel_vol;
        rd_data[CTRL_RUN_BIT]  <= run_bit;
        rd_data[CTRL_BUSY_BIT] <= busy;
      end else if (is_wiper && sel_vol) begin
        rd_data <= {1'b0, live_q[req_addr[0]]};
      end else begin
        rd_data <= nv_byte;
      end
    end
  end

  wbk_wiper_out #(.NW(NW), .CW(CODE_W)) u_out (
    .clk(clk), .rst_any(rst_any), .shdn_n(shdn_n), .run_bit(run_bit),
    .codes_in(live_q), .codes_out(codes_out), .shut_out(wiper_shut)
  );

  assign wiper0_code = codes_out[0];
  assign wiper1_code = codes_out[1];

  // R4: nothing writable moves while a commit runs
  assert_busy_lock_R4: assert property (@(posedge clk) disable iff (rst_any)
    (busy && !boot_fire) |=> ($stable(sel_vol) && $stable(run_bit) && $stable(live_q)));

  // R9: low control bits never read as 1
  assert_ctrl_low_zero_R9: assert property (@(posedge clk) disable iff (rst_any)
    ($past(req_rd) && ($past(req_addr) == ADDR_CTRL)) |-> (rd_data[4:0] == 5'd0));

  // R8: no write lands during the start-up window
  assert_boot_lock_R8: assert property (@(posedge clk) disable iff (rst_any)
    (booting && !boot_fire) |=> ($stable(sel_vol) && $stable(run_bit)));
endmodule

// File: tb/sim_wiper_bank_ctrl.sv
module sim_wiper_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WRC  = 40;
  localparam int BOOT = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       por = 1'b1;
  logic       cs_n = 1'b1;
  logic       req_wr = 1'b0;
  logic       req_rd = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       shdn_n = 1'b1;
  logic [7:0] rd_data;
  logic [6:0] wiper0_code;
  logic [6:0] wiper1_code;
  logic [1:0] wiper_shut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_bank_ctrl #(.NV_WRITE_CYCLES(WRC), .BOOT_CYCLES(BOOT)) u0 (
    .clk(clk), .rst(rst), .por(por), .cs_n(cs_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .shdn_n(shdn_n), .rd_data(rd_data),
    .wiper0_code(wiper0_code), .wiper1_code(wiper1_code), .wiper_shut(wiper_shut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_power_on();
    logic [7:0] v;
    por = 1'b1; idle(3); por = 1'b0; idle(2);
    chk("R8 mid-scale wiper0 during start-up", {1'b0, wiper0_code}, 8'h40);
    chk("R8 mid-scale wiper1 during start-up", {1'b0, wiper1_code}, 8'h40);
    chk("R6 no shutdown after reset", {6'd0, wiper_shut}, 8'h00);
    rd(4'd8, v);
    chk("R9 idle control register", v, 8'h40);
    idle(BOOT + 4);
    chk("R10 por-cleared reload wiper0", {1'b0, wiper0_code}, 8'h00);
    chk("R10 por-cleared reload wiper1", {1'b0, wiper1_code}, 8'h00);
  endtask

  task automatic t_stored_write();
    logic [7:0] v;
    cs_n = 1'b0;
    wr(4'd8, 8'h40);
    wr(4'd0, 8'h77);
    idle(2);
    chk("R3 stored write moves wiper0", {1'b0, wiper0_code}, 8'h77);
    @(negedge clk); cs_n = 1'b1;
    idle(1);
    rd(4'd8, v);
    chk("R4 busy bit set after cs rise", v, 8'h60);
    cs_n = 1'b0;
    wr(4'd8, 8'hC0);
    wr(4'd1, 8'h33);
    @(negedge clk); cs_n = 1'b1;
    rd(4'd8, v);
    chk("R4 control write refused while busy", v, 8'h60);
    idle(2);
    chk("R4 wiper1 write refused while busy", {1'b0, wiper1_code}, 8'h00);
    rd(4'd0, v);
    chk("R5 old stored byte before commit ends", v, 8'h00);
    idle(WRC + 5);
    rd(4'd8, v);
    chk("R4 busy bit clear after commit", v, 8'h40);
    rd(4'd0, v);
    chk("R5 stored byte after commit", v, 8'h77);
  endtask

  task automatic t_volatile_select();
    logic [7:0] v;
    cs_n = 1'b0;
    wr(4'd8, 8'hC0);
    wr(4'd0, 8'h12);
    @(negedge clk); cs_n = 1'b1;
    idle(2);
    chk("R2 live write moves wiper0", {1'b0, wiper0_code}, 8'h12);
    rd(4'd8, v);
    chk("R2 live write starts no commit", v, 8'hC0);
    rd(4'd0, v);
    chk("R2 live code read back", v, 8'h12);
    wr(4'd8, 8'h40);
    rd(4'd0, v);
    chk("R3 stored byte read with select 0", v, 8'h77);
    idle(1);
    chk("R3 stored read leaves wiper0", {1'b0, wiper0_code}, 8'h12);
  endtask

  task automatic t_general();
    logic [7:0] v;
    cs_n = 1'b0;
    wr(4'd3, 8'hA5);
    @(negedge clk); cs_n = 1'b1;
    idle(WRC + 5);
    rd(4'd3, v);
    chk("R1 general byte at address 3", v, 8'hA5);
    cs_n = 1'b0;
    wr(4'd7, 8'hFF);
    @(negedge clk); cs_n = 1'b1;
    idle(1);
    rd(4'd7, v);
    chk("R1 reserved address reads zero", v, 8'h00);
    rd(4'd8, v);
    chk("R1 reserved write starts no commit", v, 8'h40);
  endtask

  task automatic t_shutdown();
    logic [7:0] v;
    wr(4'd8, 8'hC0);
    @(negedge clk); shdn_n = 1'b0;
    idle(2);
    chk("R6 pin shutdown flags", {6'd0, wiper_shut}, 8'h03);
    chk("R7 wiper0 held in shutdown", {1'b0, wiper0_code}, 8'h12);
    wr(4'd1, 8'h5A);
    rd(4'd1, v);
    chk("R7 register writable in shutdown", v, 8'h5A);
    @(negedge clk); shdn_n = 1'b1;
    idle(2);
    chk("R7 shutdown released", {6'd0, wiper_shut}, 8'h00);
    chk("R7 wiper1 code after shutdown", {1'b0, wiper1_code}, 8'h5A);
    chk("R7 wiper0 code after shutdown", {1'b0, wiper0_code}, 8'h12);
    wr(4'd8, 8'h80);
    idle(2);
    chk("R6 control bit shutdown", {6'd0, wiper_shut}, 8'h03);
    rd(4'd8, v);
    chk("R9 control read with run bit low", v, 8'h80);
    wr(4'd8, 8'hC0);
    idle(2);
    chk("R6 control bit release", {6'd0, wiper_shut}, 8'h00);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0;
    idle(2);
    chk("R8 soft reset mid-scale wiper0", {1'b0, wiper0_code}, 8'h40);
    wr(4'd8, 8'h80);
    idle(BOOT + 4);
    rd(4'd8, v);
    chk("R8 write during start-up refused", v, 8'h40);
    chk("R10 stored code kept over rst wiper0", {1'b0, wiper0_code}, 8'h77);
    chk("R10 stored code kept over rst wiper1", {1'b0, wiper1_code}, 8'h00);
    rd(4'd3, v);
    chk("R10 general byte kept over rst", v, 8'hA5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_power_on();
    t_stored_write();
    t_volatile_select();
    t_general();
    t_shutdown();
    t_soft_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule